// File: doc/BRIEF.md
# UART Receive Buffer Stop Controller

This block sits behind a UART bit deserializer and moves received bytes into a byte buffer in memory. Software supplies a base address and a length. Each received byte first enters a small receive FIFO. A buffer writer then moves it to memory through a simple one-byte write port, one byte per cycle, while the buffer still has room. The block drives the RTS flow-control output toward the far-end transmitter.

A stop request does not end reception at once. It drops RTS and starts a draining phase, because a transmitter that reacts slowly to RTS may still send a few bytes. The phase ends when the line has been quiet for a programmable number of bit-time ticks, or when a fixed number of extra bytes has arrived, whichever happens first. Bytes that fit go into the buffer. The rest stay in the FIFO. An end event then reports how many bytes landed in the buffer. A later flush command moves the held bytes into a fresh buffer. A start command also writes any held bytes first, ahead of new traffic.

Top module: `uart_rxbuf_ctrl`

## Requirements
- R1: After reset, rts is 0, rx_stopped is 1, overrun is 0, and neither mem_we nor end_evt is asserted.
- R2: cmd_start, taken only while rx_stopped is 1, loads cfg_base and cfg_len, clears the byte count and raises rts at the next clock. Received bytes are then written to cfg_base+0, cfg_base+1, … in arrival order.
- R3: cmd_stop during reception lowers rts at the next clock edge. No end event is raised at that time.
- R4: After cmd_stop, at most 4 further bytes are accepted. A later byte is neither written nor kept in the FIFO.
- R5: Draining ends once cfg_timeout bit_tick pulses have occurred with no byte received. The count restarts on every accepted byte, so bytes spaced more closely than the timeout are all accepted.
- R6: The end of a receive gives a one-cycle end_evt pulse. end_count holds the number of bytes written to the current buffer. When a stop completes, rx_stopped is 1 in that same cycle.
- R7: A byte is never written at or beyond cfg_base+cfg_len. Bytes that do not fit stay in the FIFO.
- R8: cmd_flush, taken while rx_stopped is 1, loads a new base and length and writes the held FIFO bytes there in order. It then raises end_evt with that count and leaves rts at 0 and rx_stopped at 1.
- R9: If the buffer fills before any stop, end_evt is raised with end_count equal to cfg_len. rts goes to 0, rx_stopped stays 0, and further bytes go into the FIFO.
- R10: The FIFO holds 4 bytes. A byte that arrives while the FIFO is full is dropped and sets overrun. overrun stays set until the next cmd_start clears it.
- R11: On a start, bytes already held in the FIFO are written first, beginning at the new base address.
- R12: While rx_stopped is 1, byte_vld strobes are ignored and no memory writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe from the deserializer: a byte is ready |
| byte_data | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per bit time, used to time line inactivity |
| cmd_start | input | 1 | Pulse: begin reception into a new buffer |
| cmd_stop | input | 1 | Pulse: request a stop |
| cmd_flush | input | 1 | Pulse: move held bytes into a new buffer |
| cfg_base | input | AW | Buffer base address, sampled on start or flush |
| cfg_len | input | LW | Buffer length in bytes, sampled on start or flush |
| cfg_timeout | input | TW | Inactivity limit in bit ticks |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| rts | output | 1 | 1 = far end may transmit |
| end_evt | output | 1 | One-cycle end-of-receive pulse |
| end_count | output | LW | Bytes written to the buffer, valid with end_evt |
| rx_stopped | output | 1 | Reception is stopped |
| overrun | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |

## Verification
An accepted byte shows up as a memory write in the cycle after its strobe edge. rts and overrun change at the clock edge that samples the command or byte, so the bench reads them at the falling edge right after that pulse. An end event arrives after a variable number of cycles, set by the drain timeout or by the remaining writes. The bench therefore records every end_evt, together with end_count and rx_stopped, in a falling-edge monitor and waits for the event with a bounded loop. Memory contents are rebuilt from the same monitor and compared with the bytes the bench sent.

// File: rtl/rxbs_pkg.sv
package rxbs_pkg;
  typedef enum logic [2:0] {
    RX_STOPPED = 3'd0,
    RX_RUN     = 3'd1,
    RX_HELD    = 3'd2,
    RX_DRAIN   = 3'd3,
    RX_FLUSH   = 3'd4
  } rx_state_e;
endpackage

// File: rtl/rxbs_fifo.sv
module rxbs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW:0]  wr_ptr_q, wr_ptr_d;
  logic [PW:0]  rd_ptr_q, rd_ptr_d;
  logic [W-1:0] slot_q [DEPTH];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q[PW-1:0] == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= din;
    end
  end

  assign dout  = slot_q[rd_ptr_q[PW-1:0]];
  assign empty = (wr_ptr_q == rd_ptr_q);
  assign full  = (wr_ptr_q[PW] != rd_ptr_q[PW]) &&
                 (wr_ptr_q[PW-1:0] == rd_ptr_q[PW-1:0]);

  // R10: the controller must never push into a full queue
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  // R7: the buffer writer must never pop an empty queue
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/rxbs_idle_timer.sv
module rxbs_idle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = arm && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!arm || restart)      cnt_d = '0;
    else if (tick && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: a freshly armed window with a nonzero limit starts unexpired
  p_fresh_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arm) && (limit != '0)) |-> !expired);
endmodule

// File: rtl/uart_rxbuf_ctrl.sv
module uart_rxbuf_ctrl
  import rxbs_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LW         = 8,
  parameter int TW         = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int STOP_EXTRA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          bit_tick,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_flush,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  input  logic [TW-1:0] cfg_timeout,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          rts,
  output logic          end_evt,
  output logic [LW-1:0] end_count,
  output logic          rx_stopped,
  output logic          overrun
);
  localparam int XW = $clog2(STOP_EXTRA + 1);
  localparam logic [XW-1:0] EXTRA_LIM = XW'(STOP_EXTRA);

  rx_state_e     state_q, state_d;
  logic [AW-1:0] base_q, base_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] count_q, count_d;
  logic [XW-1:0] extra_q, extra_d;
  logic          evt_q, evt_d;
  logic [LW-1:0] evt_cnt_q, evt_cnt_d;
  logic          ovr_q, ovr_d;

  logic          fifo_full, fifo_empty, fifo_push;
  logic [7:0]    fifo_dout;
  logic          tmo_exp, drain_arm;
  logic          write_state, has_space, wr_go;
  logic          stop_done, take_state, rx_take, ovr_hit;

  // datapath conditions
  assign write_state = (state_q == RX_RUN) || (state_q == RX_DRAIN) ||
                       (state_q == RX_FLUSH);
  assign has_space   = (count_q != len_q);
  assign wr_go       = write_state && !fifo_empty && has_space;
  assign stop_done   = (extra_q == EXTRA_LIM) || tmo_exp;
  assign take_state  = (state_q == RX_RUN) || (state_q == RX_HELD) ||
                       ((state_q == RX_DRAIN) && !stop_done);
  assign rx_take     = byte_vld && take_state;
  assign fifo_push   = rx_take && !fifo_full;
  assign ovr_hit     = rx_take && fifo_full;
  assign drain_arm   = (state_q == RX_DRAIN);

  rxbs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (byte_data),
    .pop   (wr_go),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  rxbs_idle_timer #(.TW(TW)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (drain_arm),
    .restart (rx_take),
    .tick    (bit_tick),
    .limit   (cfg_timeout),
    .expired (tmo_exp)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    base_d    = base_q;
    len_d     = len_q;
    count_d   = count_q;
    extra_d   = extra_q;
    evt_d     = 1'b0;
    evt_cnt_d = evt_cnt_q;
    ovr_d     = ovr_q;

    if (wr_go)   count_d = count_q + 1'b1;
    if (ovr_hit) ovr_d   = 1'b1;

    unique case (state_q)
      RX_STOPPED: begin
        if (cmd_start) begin
          state_d = RX_RUN;
          base_d  = cfg_base;
          len_d   = cfg_len;
          count_d = '0;
          ovr_d   = 1'b0;
        end else if (cmd_flush) begin
          state_d = RX_FLUSH;
          base_d  = cfg_base;
          len_d   = cfg_len;
          count_d = '0;
        end
      end
      RX_RUN: begin
        if (cmd_stop) begin
          state_d = RX_DRAIN;
          extra_d = '0;
        end else if (!has_space) begin
          state_d   = RX_HELD;
          evt_d     = 1'b1;
          evt_cnt_d = count_q;
        end
      end
      RX_HELD: begin
        if (cmd_stop) begin
          state_d = RX_DRAIN;
          extra_d = '0;
        end
      end
      RX_DRAIN: begin
        if (rx_take) extra_d = extra_q + 1'b1;
        if (stop_done && !wr_go) begin
          state_d   = RX_STOPPED;
          evt_d     = 1'b1;
          evt_cnt_d = count_q;
        end
      end
      RX_FLUSH: begin
        if (!wr_go) begin
          state_d   = RX_STOPPED;
          evt_d     = 1'b1;
          evt_cnt_d = count_q;
        end
      end
      default: state_d = RX_STOPPED;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_STOPPED;
      base_q    <= '0;
      len_q     <= '0;
      count_q   <= '0;
      extra_q   <= '0;
      evt_q     <= 1'b0;
      evt_cnt_q <= '0;
      ovr_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      base_q    <= base_d;
      len_q     <= len_d;
      count_q   <= count_d;
      extra_q   <= extra_d;
      evt_q     <= evt_d;
      evt_cnt_q <= evt_cnt_d;
      ovr_q     <= ovr_d;
    end
  end

  assign mem_we     = wr_go;
  assign mem_addr   = base_q + AW'(count_q);
  assign mem_wdata  = fifo_dout;
  assign rts        = (state_q == RX_RUN);
  assign rx_stopped = (state_q == RX_STOPPED);
  assign end_evt    = evt_q;
  assign end_count  = evt_cnt_q;
  assign overrun    = ovr_q;

  // R3: a stop during reception drops flow control on the next edge
  p_rts_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_RUN && cmd_stop) |=> !rts);
  // R4: once the extra-byte allowance is used, nothing more enters the queue
  p_extra_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DRAIN && extra_q == EXTRA_LIM) |-> !fifo_push);
  // R6: end event is a single-cycle pulse
  p_end_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !end_evt);
  // R7: writes stay inside the buffer
  p_in_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (count_q < len_q));
  // R12: stopped and no command means no write next cycle
  p_stopped_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stopped && !cmd_start && !cmd_flush) |=> !mem_we);
endmodule

// File: tb/tb_uart_rxbuf_ctrl.sv
`timescale 1ns/1ps
module tb_uart_rxbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld, bit_tick, cmd_start, cmd_stop, cmd_flush;
  logic [7:0]  byte_data;
  logic [15:0] cfg_base;
  logic [7:0]  cfg_len, cfg_timeout;
  logic        mem_we, rts, end_evt, rx_stopped, overrun;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, end_count;

  int checks = 0;
  int errors = 0;
  int ev_cnt = 0;
  int ev_last = 0;
  int ev_stopped = 0;
  int wr_cnt = 0;
  logic [7:0] mem_m [0:1023];

  always #2.5 clk = ~clk;

  uart_rxbuf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .bit_tick(bit_tick), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_flush(cmd_flush), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_timeout(cfg_timeout), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rts(rts), .end_evt(end_evt),
    .end_count(end_count), .rx_stopped(rx_stopped), .overrun(overrun)
  );

  // falling-edge monitor: memory model and event log
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      mem_m[mem_addr[9:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (rst_n && end_evt) begin
      ev_cnt     <= ev_cnt + 1;
      ev_last    <= int'(end_count);
      ev_stopped <= int'(rx_stopped);
    end
  end

  // one bit tick every 4 cycles
  initial begin
    bit_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(negedge clk);
    byte_vld  = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_start(input logic [15:0] base, input logic [7:0] len);
    @(negedge clk);
    cfg_base = base; cfg_len = len; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic do_flush(input logic [15:0] base, input logic [7:0] len);
    @(negedge clk);
    cfg_base = base; cfg_len = len; cmd_flush = 1'b1;
    @(negedge clk);
    cmd_flush = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
  endtask

  task automatic wait_ev(input int prev, input string tag);
    int n = 0;
    while (ev_cnt == prev && n < 500) begin
      @(posedge clk);
      n++;
    end
    chk(tag, ev_cnt, prev + 1);
  endtask

  task automatic t_reset();
    chk("R1 rts after reset", int'(rts), 0);
    chk("R1 rx_stopped after reset", int'(rx_stopped), 1);
    chk("R1 overrun after reset", int'(overrun), 0);
    chk("R1 mem_we after reset", int'(mem_we), 0);
    chk("R1 end_evt after reset", int'(end_evt), 0);
  endtask

  task automatic t_timeout_stop();
    int e0;
    do_start(16'h000, 8'd16);
    chk("R2 rts raised by start", int'(rts), 1);
    for (int i = 0; i < 6; i++) send_byte(8'h11 + 8'(i), 2);
    e0 = ev_cnt;
    do_stop();
    chk("R3 rts low after stop", int'(rts), 0);
    chk("R3 no event at stop", ev_cnt, e0);
    wait_ev(e0, "R5 timeout ends drain");
    chk("R6 end count", ev_last, 6);
    chk("R6 stopped with event", ev_stopped, 1);
    for (int i = 0; i < 6; i++) chk("R2 buffer byte", int'(mem_m[i]), 8'h11 + i);
  endtask

  task automatic t_extra_limit();
    int e0, w0;
    do_start(16'h040, 8'd16);
    for (int i = 0; i < 6; i++) send_byte(8'h21 + 8'(i), 2);
    e0 = ev_cnt;
    do_stop();
    for (int i = 0; i < 4; i++) send_byte(8'h31 + 8'(i), 18);
    wait_ev(e0, "R4 drain ends after four bytes");
    chk("R5 spaced bytes all taken, count", ev_last, 10);
    chk("R5 last extra byte", int'(mem_m[16'h049]), 8'h34);
    w0 = wr_cnt;
    send_byte(8'h3F, 4);
    chk("R12 no write while stopped", wr_cnt, w0);
    chk("R4 fifth byte not written", int'(mem_m[16'h04A]), 0);
    e0 = ev_cnt;
    do_flush(16'h080, 8'd8);
    wait_ev(e0, "R8 flush event");
    chk("R4 fifth byte not held", ev_last, 0);
  endtask

  task automatic t_short_buffer();
    int e0;
    do_start(16'h100, 8'd8);
    for (int i = 0; i < 6; i++) send_byte(8'h41 + 8'(i), 2);
    e0 = ev_cnt;
    do_stop();
    for (int i = 0; i < 4; i++) send_byte(8'h51 + 8'(i), 2);
    wait_ev(e0, "R6 short buffer event");
    chk("R7 count capped at length", ev_last, 8);
    chk("R7 nothing past end", int'(mem_m[16'h108]), 0);
    e0 = ev_cnt;
    do_flush(16'h200, 8'd16);
    wait_ev(e0, "R8 flush event");
    chk("R8 flush count", ev_last, 2);
    chk("R8 first held byte", int'(mem_m[16'h200]), 8'h53);
    chk("R8 second held byte", int'(mem_m[16'h201]), 8'h54);
    @(negedge clk);
    chk("R8 rts low after flush", int'(rts), 0);
    chk("R8 stopped after flush", int'(rx_stopped), 1);
  endtask

  task automatic t_fill_first();
    int e0;
    e0 = ev_cnt;
    do_start(16'h300, 8'd3);
    for (int i = 0; i < 3; i++) send_byte(8'h61 + 8'(i), 2);
    wait_ev(e0, "R9 event on full buffer");
    chk("R9 count equals length", ev_last, 3);
    chk("R9 not stopped", ev_stopped, 0);
    @(negedge clk);
    chk("R9 rts low when full", int'(rts), 0);
    for (int i = 0; i < 4; i++) send_byte(8'h71 + 8'(i), 2);
    chk("R10 no overrun at four held", int'(overrun), 0);
    send_byte(8'h7F, 0);
    chk("R10 overrun on fifth", int'(overrun), 1);
    e0 = ev_cnt;
    do_stop();
    wait_ev(e0, "R5 timeout after full");
    chk("R9 count stays at length", ev_last, 3);
    do_start(16'h380, 8'd8);
    chk("R10 overrun cleared by start", int'(overrun), 0);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R11 held byte first", int'(mem_m[16'h380 + i]), 8'h71 + i);
    chk("R10 dropped byte absent", int'(mem_m[16'h384]), 0);
    e0 = ev_cnt;
    do_stop();
    wait_ev(e0, "R6 event after restart");
    chk("R11 drained count", ev_last, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_m[i] = 8'h00;
    rst_n = 1'b0; byte_vld = 1'b0; byte_data = 8'h00;
    cmd_start = 1'b0; cmd_stop = 1'b0; cmd_flush = 1'b0;
    cfg_base = '0; cfg_len = '0; cfg_timeout = 8'd8;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timeout_stop();
    t_extra_limit();
    t_short_buffer();
    t_fill_first();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule